// File: doc/BRIEF.md
# Fast-to-Slow Single-Event Handshake Crossing

This block moves a one-cycle event from a fast source clock into a slower destination clock. The destination clock has no phase relation to the source clock. Sampling such a short pulse directly in the slow domain can miss it. The source side therefore turns the pulse into a request level. It holds that level until the destination has acknowledged it, so the slow clock always sees it for more than one of its own cycles.

The destination synchronizes the request and emits exactly one pulse, one destination cycle wide, when the synchronized request rises. It echoes the synchronized request back as an acknowledge. The source synchronizes the acknowledge, drops the request when the acknowledge is high, and becomes free again once the acknowledge has fallen. This completes a four-phase handshake.

A busy output tells the sender when a new event would be lost. An event presented while busy is high is dropped on purpose. Each control level crossing a domain passes through a synchronizer chain of `SYNC_STAGES` flops, with a minimum of two. Each domain has its own synchronous active-low reset.

Top module: `pulse_xfer_top`

## Requirements
- R1: While its domain's reset is low across a clock edge, `src_busy` (source) and `dst_pulse` (destination) read 0. After both resets are released with no event, no `dst_pulse` occurs.
- R2: A `src_pulse` high at a source edge where `src_busy` is 0 is accepted. `src_busy` reads 1 from the next source cycle, and the internal request stays high until the returned acknowledge is seen.
- R3: Each accepted event yields exactly one `dst_pulse`, and that pulse is high for a single destination cycle.
- R4: A `src_pulse` at a source edge where `src_busy` is 1 is ignored and produces no extra `dst_pulse`. This holds during the request phase and during the acknowledge tail.
- R5: After acceptance, `src_busy` returns to 0 no later than 2·(S+1)·(Td+Ts)+Ts, where S is the stage count, Td is the destination period and Ts is the source period.
- R6: The `dst_pulse` of an accepted event appears no later than (S+1)·Td after the accepting source edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Fast source clock |
| src_rst_n | input | 1 | Source synchronous reset, active low |
| src_pulse | input | 1 | One-cycle event in the source domain |
| src_busy | output | 1 | High while a handshake is in flight; events are dropped |
| dst_clk | input | 1 | Slow destination clock |
| dst_rst_n | input | 1 | Destination synchronous reset, active low |
| dst_pulse | output | 1 | One-cycle event in the destination domain |

## Verification
The bench counts accepted events and destination pulses over several clock ratios and event spacings. A request that clears early, or an acknowledge that lingers, shows up as a wrong pulse count once the batch has drained. A latched request that never clears shows as `src_busy` stuck high, and this breaks the R5 bound within a few slow cycles. A pulse edge detector that stays on shows a two-cycle-wide `dst_pulse` on the next event. A busy flag that drops too early lets a second event through, which gives an extra pulse in the R4 test.

// File: rtl/pxs_pkg.sv
// Shared constants and helpers for the pulse crossing.
// Assumes: none.
package pxs_pkg;
    localparam int unsigned PXS_MIN_STAGES = 2;

    // Clamp a requested synchronizer depth to the safe minimum.
    function automatic int unsigned pxs_stages(input int unsigned want);
        return (want < PXS_MIN_STAGES) ? PXS_MIN_STAGES : want;
    endfunction
endpackage

// File: rtl/pxs_sync_chain.sv
// Multi-flop level synchronizer into the clock `clk`.
// Assumes: the input `d` is a level held for longer than one `clk` period.
module pxs_sync_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stage_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First flop: samples the asynchronous level.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= 1'b0;
                    else        stage_q[0] <= d;
                end
            end else begin : g_next
                // Later flops: let any metastable state settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[i] <= 1'b0;
                    else        stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pxs_src_ctl.sv
// Source-side handshake: captures an event into a request level and
// clears it when the synchronized acknowledge arrives.
// Assumes: ack_sync is already synchronized to clk.
module pxs_src_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    input  logic ack_sync,
    output logic req,
    output logic busy
);
    // Busy covers both the request phase and the acknowledge tail.
    assign busy = req | ack_sync;

    // Request level: set on an accepted event, cleared by the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)               req <= 1'b0;
        else if (req && ack_sync) req <= 1'b0;
        else if (pulse_in && !busy) req <= 1'b1;
    end
endmodule

// File: rtl/pxs_dst_ctl.sv
// Destination-side handshake: echoes the synchronized request as an
// acknowledge and emits one pulse on the request's rising edge.
// Assumes: req_sync is already synchronized to clk.
module pxs_dst_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic req_sync,
    output logic ack,
    output logic pulse_out
);
    // Acknowledge follows the request one cycle late; it also serves as history.
    always_ff @(posedge clk) begin
        if (!rst_n) ack <= 1'b0;
        else        ack <= req_sync;
    end

    // Rising-edge detect, driven only by flops of this domain.
    assign pulse_out = req_sync & ~ack;
endmodule

// File: rtl/pulse_xfer_top.sv
// Carries single-cycle events from a fast clock into an unrelated slower
// clock using a four-phase request/acknowledge handshake.
// Assumes: events arrive no faster than the handshake completes; extra
// events while src_busy is high are dropped by design.
module pulse_xfer_top #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    output logic src_busy,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    localparam int unsigned STAGES = pxs_pkg::pxs_stages(SYNC_STAGES);

    logic src_req;
    logic req_at_dst;
    logic ack_level;
    logic ack_at_src;

    pxs_src_ctl u_src (
        .clk      (src_clk),
        .rst_n    (src_rst_n),
        .pulse_in (src_pulse),
        .ack_sync (ack_at_src),
        .req      (src_req),
        .busy     (src_busy)
    );

    pxs_sync_chain #(.STAGES(STAGES)) u_req_sync (
        .clk   (dst_clk),
        .rst_n (dst_rst_n),
        .d     (src_req),
        .q     (req_at_dst)
    );

    pxs_dst_ctl u_dst (
        .clk       (dst_clk),
        .rst_n     (dst_rst_n),
        .req_sync  (req_at_dst),
        .ack       (ack_level),
        .pulse_out (dst_pulse)
    );

    pxs_sync_chain #(.STAGES(STAGES)) u_ack_sync (
        .clk   (src_clk),
        .rst_n (src_rst_n),
        .d     (ack_level),
        .q     (ack_at_src)
    );
endmodule

// File: rtl/pxs_checker.sv
// Protocol checks for pulse_xfer_top, attached by bind.
// Assumes: synchronous active-low resets in both domains.
module pxs_checker (
    input logic src_clk,
    input logic src_rst_n,
    input logic src_pulse,
    input logic src_busy,
    input logic src_req,
    input logic ack_at_src,
    input logic dst_clk,
    input logic dst_rst_n,
    input logic dst_pulse
);
    logic src_rst_seen;
    logic dst_rst_seen;

    // Remember that a reset edge has passed in each domain.
    always_ff @(posedge src_clk) src_rst_seen <= !src_rst_n;
    always_ff @(posedge dst_clk) dst_rst_seen <= !dst_rst_n;

    // R1: outputs are idle once a reset edge has been taken.
    always @(negedge src_clk) begin
        if (src_rst_seen && !src_rst_n)
            a_r1_src_idle: assert (!src_busy) else $error("src_busy high in reset");
    end
    always @(negedge dst_clk) begin
        if (dst_rst_seen && !dst_rst_n)
            a_r1_dst_idle: assert (!dst_pulse) else $error("dst_pulse high in reset");
    end

    // R2: an accepted event makes busy visible on the next cycle.
    a_r2_busy_after_capture: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (src_pulse && !src_busy) |=> src_busy);

    // R2: the request holds until the acknowledge returns.
    a_r2_req_held: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (src_req && !ack_at_src) |=> src_req);

    // R3: a destination pulse lasts one destination cycle.
    a_r3_pulse_one_cycle: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_pulse |=> !dst_pulse);

    // R4: an event during the acknowledge tail does not re-arm the request.
    a_r4_no_rearm_in_tail: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (ack_at_src && !src_req) |=> !src_req);
endmodule

bind pulse_xfer_top pxs_checker chk_i (
    .src_clk    (src_clk),
    .src_rst_n  (src_rst_n),
    .src_pulse  (src_pulse),
    .src_busy   (src_busy),
    .src_req    (src_req),
    .ack_at_src (ack_at_src),
    .dst_clk    (dst_clk),
    .dst_rst_n  (dst_rst_n),
    .dst_pulse  (dst_pulse)
);

// File: tb/pulse_xfer_top_tb_top.sv
`timescale 1ns/1ps
module pulse_xfer_top_tb_top;
    localparam int STAGES = 2;
    localparam int TS     = 20;

    logic src_clk = 1'b0;
    logic dst_clk = 1'b0;
    logic src_rst_n = 1'b0;
    logic dst_rst_n = 1'b0;
    logic src_pulse = 1'b0;
    logic src_busy;
    logic dst_pulse;

    int dst_half = 13;
    int checks = 0;
    int fails = 0;
    int dst_count = 0;
    int accepted = 0;
    bit mon_en = 1'b0;
    bit dprev = 1'b0;
    bit bprev = 1'b0;
    realtime cap_t = 0;
    realtime bstart = 0;

    always #10 src_clk = ~src_clk;
    always #(dst_half) dst_clk = ~dst_clk;

    pulse_xfer_top #(.SYNC_STAGES(STAGES)) dut_i (
        .src_clk   (src_clk),
        .src_rst_n (src_rst_n),
        .src_pulse (src_pulse),
        .src_busy  (src_busy),
        .dst_clk   (dst_clk),
        .dst_rst_n (dst_rst_n),
        .dst_pulse (dst_pulse)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Destination monitor: R3 width, R6 latency, pulse counting.
    always @(negedge dst_clk) begin
        if (dst_rst_n && mon_en) begin
            if (dst_pulse) begin
                int lat;
                int bound;
                lat = int'($realtime - cap_t);
                bound = (STAGES + 1) * 2 * dst_half;
                dst_count++;
                check(!dprev, "R3 pulse width", 2, 1);
                check(lat <= bound, "R6 pulse latency ns", lat, bound);
            end
            dprev = dst_pulse;
        end else begin
            dprev = 1'b0;
        end
    end

    // Source monitor: R5 handshake duration.
    always @(negedge src_clk) begin
        if (src_rst_n && mon_en) begin
            if (src_busy && !bprev) bstart = $realtime;
            if (!src_busy && bprev) begin
                int dur;
                int bound;
                dur = int'($realtime - bstart);
                bound = 2 * (STAGES + 1) * (2 * dst_half + TS) + TS;
                check(dur <= bound, "R5 busy duration ns", dur, bound);
            end
            bprev = src_busy;
        end else begin
            bprev = 1'b0;
        end
    end

    // Issue one event; the bench predicts acceptance from the busy port.
    task automatic issue();
        bit acc;
        @(negedge src_clk);
        acc = !src_busy;
        src_pulse = 1'b1;
        if (acc) begin
            accepted++;
            cap_t = $realtime + TS / 2;
        end
        @(negedge src_clk);
        src_pulse = 1'b0;
        if (acc) check(src_busy == 1'b1, "R2 busy after capture", src_busy, 1);
    endtask

    task automatic drain();
        repeat (120) @(negedge src_clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge src_clk);
        fails++;
        $display("FAIL watchdog expired (all requirements) actual=%0d expected=%0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int c0;
        int a0;
        int dh_list[5] = '{13, 21, 37, 58, 97};

        // R1: idle outputs while both resets are held.
        repeat (4) @(negedge src_clk);
        check(src_busy == 1'b0, "R1 busy in reset", src_busy, 0);
        @(negedge dst_clk);
        check(dst_pulse == 1'b0, "R1 dst_pulse in reset", dst_pulse, 0);
        src_rst_n = 1'b1;
        dst_rst_n = 1'b1;
        mon_en = 1'b1;
        c0 = dst_count;
        drain();
        check(dst_count == c0, "R1 no pulse after release", dst_count - c0, 0);

        // R3 R4 R5 R6: sweep clock ratio and event spacing.
        foreach (dh_list[k]) begin
            dst_half = dh_list[k];
            drain();
            for (int gap = 1; gap <= 24; gap++) begin
                a0 = accepted;
                c0 = dst_count;
                repeat (5) begin
                    issue();
                    repeat (gap - 1) @(negedge src_clk);
                end
                drain();
                check(accepted - a0 >= 1, "R2 at least one accepted", accepted - a0, 1);
                check(dst_count - c0 == accepted - a0, "R3 R4 pulse count",
                      dst_count - c0, accepted - a0);
            end
        end

        // R4: a back-to-back second event is ignored.
        dst_half = 37;
        drain();
        c0 = dst_count;
        issue();
        issue();
        drain();
        check(dst_count - c0 == 1, "R4 back-to-back ignored", dst_count - c0, 1);

        // R4: an event in the acknowledge tail is ignored.
        c0 = dst_count;
        issue();
        @(negedge src_clk);
        while (src_busy) begin
            issue();
        end
        drain();
        check(dst_count - c0 == 1, "R4 tail event ignored", dst_count - c0, 1);

        // R1: reset during a handshake returns both sides to idle.
        issue();
        repeat (2) @(negedge src_clk);
        mon_en = 1'b0;
        src_rst_n = 1'b0;
        dst_rst_n = 1'b0;
        repeat (12) @(negedge src_clk);
        check(src_busy == 1'b0, "R1 busy after mid reset", src_busy, 0);
        @(negedge dst_clk);
        check(dst_pulse == 1'b0, "R1 dst_pulse after mid reset", dst_pulse, 0);
        src_rst_n = 1'b1;
        dst_rst_n = 1'b1;
        mon_en = 1'b1;
        c0 = dst_count;
        drain();
        check(dst_count == c0, "R1 no stray pulse", dst_count - c0, 0);
        issue();
        drain();
        check(dst_count - c0 == 1, "R3 event after reset", dst_count - c0, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule